// File: doc/BRIEF.md
# UART Channel Mode Datapath Router

This block is the routing and control core of a serial port. It sits between the serial receiver, the push, pop and count ports of the receive and transmit FIFOs, and the processor's data register. A two-bit channel mode sets where bytes go. A byte arriving from the line can go to the receive FIFO, be sent straight back out through the transmit FIFO, do both, or be dropped. A byte that the processor writes can go to the transmit FIFO or be looped back into the receive FIFO. The serial shifters and the FIFO storage sit outside this block. The block only decides the push and pop strobes and the data that goes with them, and it reads the occupancy count of each FIFO.

A nine-bit control register holds the per-direction enable and disable bits, the self-clearing FIFO flush and timeout-restart bits, and the break start and stop bits. A byte that reaches an enabled path whose FIFO is full is reported on a one-cycle event output. A line byte that would go into a full transmit FIFO is held back with a ready/valid stall instead.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the control register reads 0x128. The break output is low, both paths are inactive, and the channel mode is 0.
- R2: Control bit 2 enables receive and bit 3 disables it. Bit 4 enables transmit and bit 5 disables it. A path is active only when its enable bit is 1 and its disable bit is 0, so disable wins.
- R3: A line byte accepted with valid and ready is routed by channel mode. Mode 0 (normal) sends it to the RX FIFO. Mode 1 (echo) sends it to both the RX and TX FIFOs. Mode 2 (local loopback) drops it. Mode 3 (remote loopback) sends it to the TX FIFO. The data goes out unchanged.
- R4: A processor data write goes to the TX FIFO in mode 0 and to the RX FIFO in mode 2. In modes 1 and 3 it has no effect.
- R5: A byte bound for an inactive path is dropped. A processor read returns the RX FIFO head and pops it only when receive is active and the FIFO is not empty. Otherwise the read returns 0 and pops nothing.
- R6: Control bits 0 (RX flush), 1 (TX flush) and 6 (timeout restart) drive their outputs for exactly the one cycle after the write that set them. The bits then read back as 0.
- R7: The break output is high exactly when control bit 7 (start break) is 1 and bit 8 (stop break) is 0.
- R8: A byte bound for an active receive path whose FIFO count equals the depth is discarded, and rx_overrun pulses high on the following cycle.
- R9: A processor write bound for an active TX FIFO that is full is discarded, and tx_overflow pulses high on the following cycle.
- R10: In modes 1 and 3, when transmit is active and the TX FIFO is full, line_rx_ready is low and the line byte is not pushed anywhere.
- R11: A line break pulse in modes 0 and 1 pushes the byte 0x00 into an active receive path. It holds line_rx_ready low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | 9 | Control register write value |
| ctrl_rd_data | output | 9 | Control register contents |
| mode_wr_en | input | 1 | Channel mode write strobe |
| mode_wr_data | input | 2 | Channel mode value |
| line_rx_valid | input | 1 | Byte from serial receiver valid |
| line_rx_data | input | DATA_W | Byte from serial receiver |
| line_rx_break | input | 1 | Break condition detected on line |
| line_rx_ready | output | 1 | Router accepts line byte |
| cpu_wr_en | input | 1 | Processor data register write |
| cpu_wr_data | input | DATA_W | Processor write byte |
| cpu_rd_en | input | 1 | Processor data register read |
| cpu_rd_data | output | DATA_W | Processor read byte |
| rxf_count | input | CNT_W | RX FIFO occupancy |
| rxf_pop_data | input | DATA_W | RX FIFO head byte |
| rxf_push | output | 1 | RX FIFO push strobe |
| rxf_push_data | output | DATA_W | RX FIFO push byte |
| rxf_pop | output | 1 | RX FIFO pop strobe |
| rxf_flush | output | 1 | RX FIFO flush |
| txf_count | input | CNT_W | TX FIFO occupancy |
| txf_push | output | 1 | TX FIFO push strobe |
| txf_push_data | output | DATA_W | TX FIFO push byte |
| txf_flush | output | 1 | TX FIFO flush |
| break_out | output | 1 | Transmit break request |
| timeout_restart | output | 1 | Receive timeout restart pulse |
| rx_overrun | output | 1 | Receive overrun event pulse |
| tx_overflow | output | 1 | Transmit overflow event pulse |

## Verification
The bench builds the block with FIFO_DEPTH = 4, which gives a three-bit count. Driving the counts straight from the bench then makes an exactly full FIFO a single value. With that small configuration the bench covers every combination of the four channel modes, all sixteen settings of the four enable and disable bits, and full or not-full on each FIFO. For each combination it checks line routing, processor writes, processor reads and the overrun and overflow pulses against values it derives itself. Directed steps then cover the reset value, the self-clearing bits, the break controls and the zero byte pushed on a line break.

// File: rtl/uart_router_pkg.sv
package uart_router_pkg;

    typedef enum logic [1:0] {
        CHM_NORMAL = 2'd0,
        CHM_ECHO   = 2'd1,
        CHM_LOCAL  = 2'd2,
        CHM_REMOTE = 2'd3
    } chmode_e;

    localparam int CTL_W        = 9;
    localparam int CB_RX_FLUSH  = 0;
    localparam int CB_TX_FLUSH  = 1;
    localparam int CB_RX_ON     = 2;
    localparam int CB_RX_OFF    = 3;
    localparam int CB_TX_ON     = 4;
    localparam int CB_TX_OFF    = 5;
    localparam int CB_TMO_RST   = 6;
    localparam int CB_BRK_GO    = 7;
    localparam int CB_BRK_HALT  = 8;

    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;

    typedef struct packed {
        logic [CTL_W-1:0] ctrl;
        chmode_e          mode;
    } ctl_state_t;

    typedef struct packed {
        logic rx_ovr;
        logic tx_ovf;
    } evt_state_t;

endpackage

// File: rtl/urt_ctrl_reg.sv
module urt_ctrl_reg
    import uart_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             mode_wr_en,
    input  logic [1:0]       mode_wr_data,
    output logic [CTL_W-1:0] ctrl_o,
    output chmode_e          mode_o,
    output logic             rx_active,
    output logic             tx_active,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             tmo_restart,
    output logic             brk_out
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.ctrl[CB_RX_FLUSH] = 1'b0;
        st_d.ctrl[CB_TX_FLUSH] = 1'b0;
        st_d.ctrl[CB_TMO_RST]  = 1'b0;
        if (wr_en) begin
            st_d.ctrl = wr_data;
        end
        if (mode_wr_en) begin
            st_d.mode = chmode_e'(mode_wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTL_RESET;
            st_q.mode <= CHM_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o      = st_q.ctrl;
    assign mode_o      = st_q.mode;
    assign rx_active   = st_q.ctrl[CB_RX_ON] & ~st_q.ctrl[CB_RX_OFF];
    assign tx_active   = st_q.ctrl[CB_TX_ON] & ~st_q.ctrl[CB_TX_OFF];
    assign rx_flush    = st_q.ctrl[CB_RX_FLUSH];
    assign tx_flush    = st_q.ctrl[CB_TX_FLUSH];
    assign tmo_restart = st_q.ctrl[CB_TMO_RST];
    assign brk_out     = st_q.ctrl[CB_BRK_GO] & ~st_q.ctrl[CB_BRK_HALT];

    // R6: self-clearing bits last one cycle unless rewritten
    p_rx_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CB_RX_FLUSH] && !wr_en) |=> !st_q.ctrl[CB_RX_FLUSH]);
    p_tx_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CB_TX_FLUSH] && !wr_en) |=> !st_q.ctrl[CB_TX_FLUSH]);
    // R6: a written value is visible the next cycle
    p_ctrl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_o == $past(wr_data)));

endmodule

// File: rtl/urt_line_route.sv
module urt_line_route
    import uart_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  chmode_e           mode,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_data,
    input  logic              line_break,
    output logic              line_ready,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ovr,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data
);

    logic feeds_rx, feeds_tx, stall, take_rx, take_line;

    always_comb begin
        feeds_rx   = (mode == CHM_NORMAL) || (mode == CHM_ECHO);
        feeds_tx   = (mode == CHM_ECHO)   || (mode == CHM_REMOTE);
        stall      = feeds_tx && tx_active && tx_full;
        line_ready = !line_break && !stall;
        take_line  = line_valid && !line_break && !stall;
        take_rx    = (line_break || take_line) && feeds_rx && rx_active;
        rx_push    = take_rx && !rx_full;
        rx_ovr     = take_rx && rx_full;
        rx_data    = line_break ? '0 : line_data;
        tx_push    = take_line && feeds_tx && tx_active;
        tx_data    = line_data;
    end

endmodule

// File: rtl/urt_cpu_route.sv
module urt_cpu_route
    import uart_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  chmode_e           mode,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              rx_full,
    input  logic              rx_empty,
    input  logic              tx_full,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] head_data,
    output logic              rx_push,
    output logic              rx_ovr,
    output logic              tx_push,
    output logic              tx_ovf,
    output logic [DATA_W-1:0] push_data,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data
);

    logic to_tx, to_rx;

    always_comb begin
        to_tx     = wr_en && (mode == CHM_NORMAL) && tx_active;
        to_rx     = wr_en && (mode == CHM_LOCAL)  && rx_active;
        tx_push   = to_tx && !tx_full;
        tx_ovf    = to_tx && tx_full;
        rx_push   = to_rx && !rx_full;
        rx_ovr    = to_rx && rx_full;
        push_data = wr_data;
        pop       = rd_en && rx_active && !rx_empty;
        rd_data   = pop ? head_data : '0;
    end

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uart_router_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_en,
    input  logic [8:0]        ctrl_wr_data,
    output logic [8:0]        ctrl_rd_data,
    input  logic              mode_wr_en,
    input  logic [1:0]        mode_wr_data,
    input  logic              line_rx_valid,
    input  logic [DATA_W-1:0] line_rx_data,
    input  logic              line_rx_break,
    output logic              line_rx_ready,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic [CNT_W-1:0]  rxf_count,
    input  logic [DATA_W-1:0] rxf_pop_data,
    output logic              rxf_push,
    output logic [DATA_W-1:0] rxf_push_data,
    output logic              rxf_pop,
    output logic              rxf_flush,
    input  logic [CNT_W-1:0]  txf_count,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_push_data,
    output logic              txf_flush,
    output logic              break_out,
    output logic              timeout_restart,
    output logic              rx_overrun,
    output logic              tx_overflow
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    chmode_e             mode;
    logic                rx_active, tx_active;
    logic                rx_full, tx_full, rx_empty;
    logic                ln_rx_push, ln_rx_ovr, ln_tx_push;
    logic [DATA_W-1:0]   ln_rx_data, ln_tx_data;
    logic                cp_rx_push, cp_rx_ovr, cp_tx_push, cp_tx_ovf;
    logic [DATA_W-1:0]   cp_data;
    evt_state_t          evt_d, evt_q;

    assign rx_full  = (rxf_count == FULL_CNT);
    assign tx_full  = (txf_count == FULL_CNT);
    assign rx_empty = (rxf_count == '0);

    urt_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctrl_wr_en),
        .wr_data      (ctrl_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .ctrl_o       (ctrl_rd_data),
        .mode_o       (mode),
        .rx_active    (rx_active),
        .tx_active    (tx_active),
        .rx_flush     (rxf_flush),
        .tx_flush     (txf_flush),
        .tmo_restart  (timeout_restart),
        .brk_out      (break_out)
    );

    urt_line_route #(.DATA_W(DATA_W)) u_line (
        .mode       (mode),
        .rx_active  (rx_active),
        .tx_active  (tx_active),
        .rx_full    (rx_full),
        .tx_full    (tx_full),
        .line_valid (line_rx_valid),
        .line_data  (line_rx_data),
        .line_break (line_rx_break),
        .line_ready (line_rx_ready),
        .rx_push    (ln_rx_push),
        .rx_data    (ln_rx_data),
        .rx_ovr     (ln_rx_ovr),
        .tx_push    (ln_tx_push),
        .tx_data    (ln_tx_data)
    );

    urt_cpu_route #(.DATA_W(DATA_W)) u_cpu (
        .mode      (mode),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .rx_full   (rx_full),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .wr_en     (cpu_wr_en),
        .wr_data   (cpu_wr_data),
        .rd_en     (cpu_rd_en),
        .head_data (rxf_pop_data),
        .rx_push   (cp_rx_push),
        .rx_ovr    (cp_rx_ovr),
        .tx_push   (cp_tx_push),
        .tx_ovf    (cp_tx_ovf),
        .push_data (cp_data),
        .pop       (rxf_pop),
        .rd_data   (cpu_rd_data)
    );

    // Line and processor sources reach a given FIFO only in disjoint modes.
    assign rxf_push      = ln_rx_push | cp_rx_push;
    assign rxf_push_data = cp_rx_push ? cp_data : ln_rx_data;
    assign txf_push      = ln_tx_push | cp_tx_push;
    assign txf_push_data = cp_tx_push ? cp_data : ln_tx_data;

    always_comb begin
        evt_d        = evt_q;
        evt_d.rx_ovr = ln_rx_ovr | cp_rx_ovr;
        evt_d.tx_ovf = cp_tx_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign rx_overrun  = evt_q.rx_ovr;
    assign tx_overflow = evt_q.tx_ovf;

    // R3 / R4: the two sources never target the RX FIFO in the same cycle
    p_single_rx_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ln_rx_push && cp_rx_push));
    // R4: nor the TX FIFO
    p_single_tx_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ln_tx_push && cp_tx_push));
    // R8: no push into a full RX FIFO; an overrun follows a full count
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push |-> (rxf_count != FULL_CNT));
    p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rxf_count) == FULL_CNT));
    // R9: overflow only follows a processor write into a full TX FIFO
    p_overflow_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_overflow |-> ($past(txf_count) == FULL_CNT && $past(cpu_wr_en)));
    // R10: a stalled line byte pushes nothing
    p_stall_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_rx_ready && !line_rx_break) |-> (!rxf_push && !txf_push));
    // R5: an inactive receiver never pops and reads zero
    p_rd_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> (!rxf_pop && cpu_rd_data == '0));

endmodule

// File: tb/tb_uart_mode_router.sv
`timescale 1ns/1ps
module tb_uart_mode_router;

    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ctrl_wr_en = 0;
    logic [8:0]    ctrl_wr_data = '0;
    logic [8:0]    ctrl_rd_data;
    logic          mode_wr_en = 0;
    logic [1:0]    mode_wr_data = '0;
    logic          line_rx_valid = 0;
    logic [DW-1:0] line_rx_data = '0;
    logic          line_rx_break = 0;
    logic          line_rx_ready;
    logic          cpu_wr_en = 0;
    logic [DW-1:0] cpu_wr_data = '0;
    logic          cpu_rd_en = 0;
    logic [DW-1:0] cpu_rd_data;
    logic [CW-1:0] rxf_count = '0;
    logic [DW-1:0] rxf_pop_data = '0;
    logic          rxf_push, rxf_pop, rxf_flush;
    logic [DW-1:0] rxf_push_data;
    logic [CW-1:0] txf_count = '0;
    logic          txf_push, txf_flush;
    logic [DW-1:0] txf_push_data;
    logic          break_out, timeout_restart, rx_overrun, tx_overflow;

    uart_mode_router #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
        .line_rx_break(line_rx_break), .line_rx_ready(line_rx_ready),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .rxf_count(rxf_count), .rxf_pop_data(rxf_pop_data),
        .rxf_push(rxf_push), .rxf_push_data(rxf_push_data),
        .rxf_pop(rxf_pop), .rxf_flush(rxf_flush),
        .txf_count(txf_count), .txf_push(txf_push),
        .txf_push_data(txf_push_data), .txf_flush(txf_flush),
        .break_out(break_out), .timeout_restart(timeout_restart),
        .rx_overrun(rx_overrun), .tx_overflow(tx_overflow)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        @(negedge clk);
        ctrl_wr_en = 1; ctrl_wr_data = v;
        @(negedge clk);
        ctrl_wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctrl reset", ctrl_rd_data, 9'h128);
        check("R1 break low", break_out, 0);
        line_rx_valid = 1; line_rx_data = 8'h11; rxf_count = 1;
        #1 check("R1 inactive no push", {rxf_push, txf_push}, 2'b00);
        line_rx_valid = 0;
        rst_n = 1;
        @(negedge clk);

        // Sweep: mode x enable/disable bits x full flags
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int f = 0; f < 4; f++) begin
                    logic rxa, txa, rfull, tfull, to_rx, to_tx, rdy;
                    logic e_lrx, e_ltx, e_lovr, e_crx, e_ctx, e_covr, e_covf;
                    logic [7:0] lb, cb;
                    rxa   = c[0] & ~c[1];
                    txa   = c[2] & ~c[3];
                    rfull = f[0];
                    tfull = f[1];
                    to_rx = (m == 0) || (m == 1);
                    to_tx = (m == 1) || (m == 3);
                    rdy   = !(to_tx && txa && tfull);
                    e_lrx  = rdy && to_rx && rxa && !rfull;
                    e_lovr = rdy && to_rx && rxa && rfull;
                    e_ltx  = rdy && to_tx && txa;
                    e_ctx  = (m == 0) && txa && !tfull;
                    e_covf = (m == 0) && txa && tfull;
                    e_crx  = (m == 2) && rxa && !rfull;
                    e_covr = (m == 2) && rxa && rfull;
                    lb = 8'(8'hA0 + m * 16 + c);
                    cb = 8'(8'h5C ^ (c * 4 + f));

                    // configure
                    ctrl_wr_en = 1;
                    ctrl_wr_data = 9'h100 | 9'(c << 2);
                    mode_wr_en = 1; mode_wr_data = 2'(m);
                    rxf_count = rfull ? CW'(DEPTH) : CW'(1);
                    txf_count = tfull ? CW'(DEPTH) : CW'(2);
                    @(negedge clk);
                    ctrl_wr_en = 0; mode_wr_en = 0;

                    // line byte: R2, R3, R5, R10
                    line_rx_valid = 1; line_rx_data = lb;
                    #1;
                    check("R10 line ready", line_rx_ready, rdy);
                    check("R3 R2 line routing", {rxf_push, txf_push}, {e_lrx, e_ltx});
                    if (e_lrx) check("R3 rx data", rxf_push_data, lb);
                    if (e_ltx) check("R3 tx data", txf_push_data, lb);
                    @(negedge clk);
                    line_rx_valid = 0;
                    check("R8 overrun after line byte", {rx_overrun, tx_overflow}, {e_lovr, 1'b0});

                    // processor write: R4, R5
                    cpu_wr_en = 1; cpu_wr_data = cb;
                    #1;
                    check("R4 R5 cpu write routing", {rxf_push, txf_push}, {e_crx, e_ctx});
                    if (e_crx) check("R4 rx data", rxf_push_data, cb);
                    if (e_ctx) check("R4 tx data", txf_push_data, cb);
                    @(negedge clk);
                    cpu_wr_en = 0;
                    check("R8 R9 events after cpu write", {rx_overrun, tx_overflow}, {e_covr, e_covf});

                    // processor read: R5
                    cpu_rd_en = 1; rxf_pop_data = cb ^ 8'hFF;
                    #1;
                    check("R5 read pop", rxf_pop, rxa);
                    check("R5 read data", cpu_rd_data, rxa ? 32'(cb ^ 8'hFF) : 32'h0);
                    @(negedge clk);
                    cpu_rd_en = 0;
                    check("R8 R9 pulse clears", {rx_overrun, tx_overflow}, 2'b00);
                end
            end
        end

        // R5: empty FIFO read with receiver active
        mode_wr_en = 1; mode_wr_data = 0;
        wr_ctrl(9'h114);
        mode_wr_en = 0;
        rxf_count = 0; cpu_rd_en = 1; rxf_pop_data = 8'h77;
        #1 check("R5 empty read", {rxf_pop, cpu_rd_data}, 9'h000);
        cpu_rd_en = 0;

        // R11: line break in normal mode pushes zero and stalls
        line_rx_break = 1; line_rx_valid = 1; line_rx_data = 8'h99; rxf_count = 1;
        #1;
        check("R11 break push", {line_rx_ready, rxf_push, txf_push}, 3'b010);
        check("R11 break data zero", rxf_push_data, 0);
        line_rx_valid = 0; line_rx_break = 0;
        // R11: break in remote loopback reaches no FIFO
        @(negedge clk);
        mode_wr_en = 1; mode_wr_data = 3;
        @(negedge clk);
        mode_wr_en = 0;
        line_rx_break = 1;
        #1 check("R11 break remote ignored", {rxf_push, txf_push}, 2'b00);
        line_rx_break = 0;

        // R6: self-clearing flush and timeout-restart bits
        @(negedge clk);
        ctrl_wr_en = 1; ctrl_wr_data = 9'h043;
        @(negedge clk);
        ctrl_wr_en = 0;
        check("R6 flush pulse", {rxf_flush, txf_flush, timeout_restart}, 3'b111);
        check("R6 ctrl readback set", ctrl_rd_data, 9'h043);
        @(negedge clk);
        check("R6 flush cleared", {rxf_flush, txf_flush, timeout_restart}, 3'b000);
        check("R6 ctrl readback cleared", ctrl_rd_data, 9'h000);

        // R7: break control
        wr_ctrl(9'h080);
        check("R7 start break", break_out, 1);
        wr_ctrl(9'h180);
        check("R7 stop wins", break_out, 0);
        wr_ctrl(9'h000);
        check("R7 neither", break_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule